// File: doc/BRIEF.md
# DMA Channel Parameter-Set Controller

This block holds a bank of transfer descriptors ("parameter sets") and turns DMA events into transfer requests for a downstream copy engine. Each of the `NCH` channels owns the descriptor with the same index. The bank has `NSET > NCH` entries, so the extra entries act as reload images that a channel can link to. A descriptor describes a three-level walk. A frame is `acnt` bytes, `bcnt` frames make a block, and `ccnt` blocks make the job. Each level has its own signed address step for the source and for the destination.

When an event arrives, the controller checks the channel's descriptor and puts one request on a valid/ready stream. Once the engine accepts the request, the controller advances the descriptor. In block mode one request covers a whole block. In frame mode one request covers a single frame. When the job ends, the controller copies the linked descriptor into the channel's slot, or clears the slot if there is no link. It then pulses a completion flag and can optionally raise an event on another channel. A descriptor that cannot produce a request raises a per-channel error pulse instead. Software programs descriptors through a one-word write port, one field per write.

The request stream follows these rules. Once `req_valid` is high, the payload holds steady until `req_ready` is seen high at a clock edge. At most one request is outstanding. The next request can appear, at the earliest, one cycle after the handshake.

Top module: `dma_ps_ctrl`

## Requirements
- R1: After reset, `req_valid`, `done_o` and `err_o` are low and every descriptor is zero, so a first event on any channel gives an error pulse.
- R2: In block mode (option bit 0 = 1), each request carries the descriptor's `src`, `dst`, `acnt`, `bcnt`, both frame steps and its queue. After acceptance, `src` and `dst` each add their block step and `ccnt` decreases by one.
- R3: In frame mode (option bit 0 = 0), each request carries `bcnt` = 1. After acceptance with `bcnt` > 1, `src` and `dst` add their frame steps and `bcnt` decreases by one.
- R4: In frame mode, when `bcnt` is 1 and `ccnt` > 1, acceptance reloads `bcnt` from the reload field, applies the block steps and decreases `ccnt`. The reload field has no effect in block mode or when `ccnt` is 1.
- R5: When a request finishes the job (`ccnt` would reach 0), the channel's slot is overwritten with the descriptor named by its link field. A link value of `NSET` or more clears the slot instead.
- R6: `done_o[c]` is high for exactly the one cycle after the handshake of channel c's final request.
- R7: If option bit 1 is set and the chain target (option bits 11:4) is below `NCH`, the final request marks the target channel pending exactly as an external event would.
- R8: If option bit 2 is set, every request other than the final one marks the chain target pending. The final request does not.
- R9: An event on a channel whose `acnt`, `bcnt` or `ccnt` is zero gives a one-cycle `err_o[c]` pulse two cycles after the event. No request is issued and the descriptor is left unchanged.
- R10: While `req_valid` is high and `req_ready` is low, the payload is stable. Events on a channel that is already pending merge into one.
- R11: Among pending channels, the lowest index is served first, and `req_chan` names the channel.
- R12: All steps are signed 16-bit values, sign-extended and added modulo 2^32 to the 32-bit addresses.
- R13: Writes go to descriptor `wr_set`, field `wr_field`. The fields are:
  - 0 = src
  - 1 = dst
  - 2 = {bcnt, acnt}
  - 3 = {dst frame step, src frame step}
  - 4 = {dst block step, src block step}
  - 5 = {reload, ccnt}
  - 6 = link in bits 15:0
  - 7 = options, with mode in bit 0, final chain in bit 1, intermediate chain in bit 2, target in bits 11:4 and queue in bits 17:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_set | input | $clog2(NSET) | Descriptor index to write |
| wr_field | input | 3 | Field select (R13) |
| wr_data | input | 32 | Write data |
| evt_i | input | NCH | Per-channel event pulses |
| req_valid | output | 1 | Request available |
| req_ready | input | 1 | Copy engine accepts request |
| req_src | output | 32 | Source address |
| req_dst | output | 32 | Destination address |
| req_acnt | output | 16 | Bytes per frame |
| req_bcnt | output | 16 | Frames in this request |
| req_sbidx | output | 16 | Source frame step |
| req_dbidx | output | 16 | Destination frame step |
| req_queue | output | 2 | Target engine queue |
| req_chan | output | $clog2(NCH) | Requesting channel |
| done_o | output | NCH | Completion pulses |
| err_o | output | NCH | Error pulses |

## Verification
The assertions take the following for granted about the inputs:
- The write port never touches a descriptor while that descriptor's channel has a request outstanding.
- A link never points at the slot it is loaded into.
- `req_ready` may change freely, but only between edges.

The stimulus programs descriptors only while the stream is idle, and it links channels only to reload entries above `NCH`. In the random phase, events and back-pressure are driven at arbitrary rates. A behavioural model of descriptor walking is compared on every clock.

// File: rtl/dma_ps_pkg.sv
package dma_ps_pkg;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] acnt;
    logic [15:0] bcnt;
    logic [15:0] ccnt;
    logic [15:0] brld;
    logic [15:0] sbidx;
    logic [15:0] dbidx;
    logic [15:0] scidx;
    logic [15:0] dcidx;
    logic [15:0] link;
    logic        blk_mode;
    logic        chn_fin;
    logic        chn_mid;
    logic [7:0]  chn_tgt;
    logic [1:0]  queue;
  } pset_t;

  typedef enum logic [2:0] {
    FLD_SRC  = 3'd0,
    FLD_DST  = 3'd1,
    FLD_AB   = 3'd2,
    FLD_BIDX = 3'd3,
    FLD_CIDX = 3'd4,
    FLD_C    = 3'd5,
    FLD_LINK = 3'd6,
    FLD_OPT  = 3'd7
  } field_e;

  function automatic logic [31:0] step_addr(input logic [31:0] a, input logic [15:0] off);
    return a + {{16{off[15]}}, off};
  endfunction

endpackage

// File: rtl/dma_ps_arb.sv
module dma_ps_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_ps_step.sv
module dma_ps_step
  import dma_ps_pkg::*;
(
  input  pset_t       cur,
  output logic        bad,
  output logic        fin,
  output logic        mid,
  output logic [15:0] req_bcnt,
  output pset_t       nxt
);
  always_comb begin
    nxt      = cur;
    fin      = 1'b0;
    req_bcnt = cur.bcnt;
    bad      = (cur.acnt == 16'd0) || (cur.bcnt == 16'd0) || (cur.ccnt == 16'd0);
    if (cur.blk_mode) begin
      nxt.src  = step_addr(cur.src, cur.scidx);
      nxt.dst  = step_addr(cur.dst, cur.dcidx);
      nxt.ccnt = cur.ccnt - 16'd1;
      fin      = (cur.ccnt == 16'd1);
    end else begin
      req_bcnt = 16'd1;
      if (cur.bcnt > 16'd1) begin
        nxt.src  = step_addr(cur.src, cur.sbidx);
        nxt.dst  = step_addr(cur.dst, cur.dbidx);
        nxt.bcnt = cur.bcnt - 16'd1;
      end else if (cur.ccnt > 16'd1) begin
        nxt.src  = step_addr(cur.src, cur.scidx);
        nxt.dst  = step_addr(cur.dst, cur.dcidx);
        nxt.bcnt = cur.brld;
        nxt.ccnt = cur.ccnt - 16'd1;
      end else begin
        nxt.ccnt = 16'd0;
        fin      = 1'b1;
      end
    end
    mid = !fin && cur.chn_mid;
  end
endmodule

// File: rtl/dma_ps_ctrl.sv
module dma_ps_ctrl
  import dma_ps_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NSET = 16,
  localparam int CHW = $clog2(NCH),
  localparam int SW  = $clog2(NSET)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_set,
  input  logic [2:0]      wr_field,
  input  logic [31:0]     wr_data,
  input  logic [NCH-1:0]  evt_i,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [31:0]     req_src,
  output logic [31:0]     req_dst,
  output logic [15:0]     req_acnt,
  output logic [15:0]     req_bcnt,
  output logic [15:0]     req_sbidx,
  output logic [15:0]     req_dbidx,
  output logic [1:0]      req_queue,
  output logic [CHW-1:0]  req_chan,
  output logic [NCH-1:0]  done_o,
  output logic [NCH-1:0]  err_o
);

  pset_t          sets [NSET];
  logic [NCH-1:0] pend;
  logic [NCH-1:0] pick_clr;
  logic [NCH-1:0] chain_vec;
  logic           pick_any;
  logic [CHW-1:0] pick_idx;
  pset_t          step_in;
  pset_t          step_nxt;
  logic           step_bad, step_fin, step_mid;
  logic [15:0]    step_bcnt;
  logic           hs;
  logic           lnk_ok;
  logic [SW-1:0]  cur_slot;

  dma_ps_arb #(.N(NCH)) u_arb (
    .req (pend),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign cur_slot = req_valid ? SW'(req_chan) : SW'(pick_idx);
  assign step_in  = sets[cur_slot];
  assign hs       = req_valid && req_ready;
  assign lnk_ok   = step_in.link < 16'(NSET);

  dma_ps_step u_step (
    .cur      (step_in),
    .bad      (step_bad),
    .fin      (step_fin),
    .mid      (step_mid),
    .req_bcnt (step_bcnt),
    .nxt      (step_nxt)
  );

  always_comb begin
    pick_clr  = '0;
    chain_vec = '0;
    if (!req_valid && pick_any) pick_clr[pick_idx] = 1'b1;
    if (hs && (step_in.chn_tgt < 8'(NCH)) &&
        ((step_fin && step_in.chn_fin) || step_mid))
      chain_vec[step_in.chn_tgt[CHW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSET; i++) sets[i] <= '0;
      pend      <= '0;
      req_valid <= 1'b0;
      req_src   <= '0;
      req_dst   <= '0;
      req_acnt  <= '0;
      req_bcnt  <= '0;
      req_sbidx <= '0;
      req_dbidx <= '0;
      req_queue <= '0;
      req_chan  <= '0;
      done_o    <= '0;
      err_o     <= '0;
    end else begin
      done_o <= '0;
      err_o  <= '0;
      pend   <= (pend & ~pick_clr) | evt_i | chain_vec;
      if (wr_en) begin
        case (field_e'(wr_field))
          FLD_SRC:  sets[wr_set].src <= wr_data;
          FLD_DST:  sets[wr_set].dst <= wr_data;
          FLD_AB:   begin
                      sets[wr_set].acnt <= wr_data[15:0];
                      sets[wr_set].bcnt <= wr_data[31:16];
                    end
          FLD_BIDX: begin
                      sets[wr_set].sbidx <= wr_data[15:0];
                      sets[wr_set].dbidx <= wr_data[31:16];
                    end
          FLD_CIDX: begin
                      sets[wr_set].scidx <= wr_data[15:0];
                      sets[wr_set].dcidx <= wr_data[31:16];
                    end
          FLD_C:    begin
                      sets[wr_set].ccnt <= wr_data[15:0];
                      sets[wr_set].brld <= wr_data[31:16];
                    end
          FLD_LINK: sets[wr_set].link <= wr_data[15:0];
          default:  begin
                      sets[wr_set].blk_mode <= wr_data[0];
                      sets[wr_set].chn_fin  <= wr_data[1];
                      sets[wr_set].chn_mid  <= wr_data[2];
                      sets[wr_set].chn_tgt  <= wr_data[11:4];
                      sets[wr_set].queue    <= wr_data[17:16];
                    end
        endcase
      end
      if (hs) begin
        req_valid <= 1'b0;
        done_o[req_chan] <= step_fin;
        if (step_fin) sets[cur_slot] <= lnk_ok ? sets[step_in.link[SW-1:0]] : '0;
        else          sets[cur_slot] <= step_nxt;
      end else if (!req_valid && pick_any) begin
        if (step_bad) begin
          err_o[pick_idx] <= 1'b1;
        end else begin
          req_valid <= 1'b1;
          req_chan  <= pick_idx;
          req_src   <= step_in.src;
          req_dst   <= step_in.dst;
          req_acnt  <= step_in.acnt;
          req_bcnt  <= step_bcnt;
          req_sbidx <= step_in.sbidx;
          req_dbidx <= step_in.dbidx;
          req_queue <= step_in.queue;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst) &&
      $stable(req_bcnt) && $stable(req_chan)) else $error("payload moved under back-pressure"); // R10

  AST_NONZERO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_acnt != 16'd0) && (req_bcnt != 16'd0)) else $error("zero-size request"); // R9

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_o) |-> !req_valid) else $error("error alongside request"); // R9

  AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |-> $past(req_valid && req_ready)) else $error("done without handshake"); // R6

  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o)) else $error("several completions at once"); // R6

  AST_RISE_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(|pend)) else $error("request without pending channel"); // R11

endmodule

// File: tb/tb_dma_ps_ctrl.sv
module tb_dma_ps_ctrl;
  localparam int NC = 4;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_set = '0;
  logic [2:0]  wr_field = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  evt_i = '0;
  logic        req_ready = 1'b1;
  logic        req_valid;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_acnt, req_bcnt, req_sbidx, req_dbidx;
  logic [1:0]  req_queue;
  logic [1:0]  req_chan;
  logic [3:0]  done_o, err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  dma_ps_ctrl #(.NCH(NC), .NSET(NS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_field(wr_field),
    .wr_data(wr_data), .evt_i(evt_i), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_acnt(req_acnt), .req_bcnt(req_bcnt),
    .req_sbidx(req_sbidx), .req_dbidx(req_dbidx), .req_queue(req_queue),
    .req_chan(req_chan), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_src[NS], m_dst[NS];
  logic [15:0] m_acnt[NS], m_bcnt[NS], m_ccnt[NS], m_brld[NS];
  logic [15:0] m_sb[NS], m_db[NS], m_sc[NS], m_dc[NS], m_link[NS];
  logic        m_ab[NS], m_fin[NS], m_mid[NS];
  logic [7:0]  m_tgt[NS];
  logic [1:0]  m_q[NS];
  logic        m_valid = 0, m_rab = 0;
  int          m_cur = 0;
  logic [31:0] m_rsrc = 0, m_rdst = 0;
  logic [15:0] m_racnt = 0, m_rbcnt = 0, m_rsb = 0, m_rdb = 0;
  logic [1:0]  m_rq = 0;
  logic [3:0]  m_pend = 0, m_done = 0, m_err = 0;

  function automatic logic [31:0] sx(input logic [15:0] o);
    return {{16{o[15]}}, o};
  endfunction

  task automatic m_copy(input int d, input int s, input bit zero);
    m_src[d]  = zero ? 0 : m_src[s];  m_dst[d]  = zero ? 0 : m_dst[s];
    m_acnt[d] = zero ? 0 : m_acnt[s]; m_bcnt[d] = zero ? 0 : m_bcnt[s];
    m_ccnt[d] = zero ? 0 : m_ccnt[s]; m_brld[d] = zero ? 0 : m_brld[s];
    m_sb[d]   = zero ? 0 : m_sb[s];   m_db[d]   = zero ? 0 : m_db[s];
    m_sc[d]   = zero ? 0 : m_sc[s];   m_dc[d]   = zero ? 0 : m_dc[s];
    m_link[d] = zero ? 0 : m_link[s]; m_ab[d]   = zero ? 0 : m_ab[s];
    m_fin[d]  = zero ? 0 : m_fin[s];  m_mid[d]  = zero ? 0 : m_mid[s];
    m_tgt[d]  = zero ? 0 : m_tgt[s];  m_q[d]    = zero ? 0 : m_q[s];
  endtask

  always @(posedge clk) begin
    logic [3:0] chain, clr;
    logic       fin;
    int         s, c;
    chain = 0; clr = 0; fin = 0;
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_copy(i, 0, 1'b1);
      m_valid = 0; m_pend = 0; m_done = 0; m_err = 0; m_cur = 0;
      m_rsrc = 0; m_rdst = 0; m_racnt = 0; m_rbcnt = 0; m_rsb = 0; m_rdb = 0; m_rq = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (wr_en) begin
        s = int'(wr_set);
        case (wr_field)
          3'd0: m_src[s] = wr_data;
          3'd1: m_dst[s] = wr_data;
          3'd2: begin m_acnt[s] = wr_data[15:0]; m_bcnt[s] = wr_data[31:16]; end
          3'd3: begin m_sb[s] = wr_data[15:0]; m_db[s] = wr_data[31:16]; end
          3'd4: begin m_sc[s] = wr_data[15:0]; m_dc[s] = wr_data[31:16]; end
          3'd5: begin m_ccnt[s] = wr_data[15:0]; m_brld[s] = wr_data[31:16]; end
          3'd6: m_link[s] = wr_data[15:0];
          default: begin
            m_ab[s] = wr_data[0]; m_fin[s] = wr_data[1]; m_mid[s] = wr_data[2];
            m_tgt[s] = wr_data[11:4]; m_q[s] = wr_data[17:16];
          end
        endcase
      end
      if (m_valid) begin
        if (req_ready) begin
          s = m_cur;
          m_valid = 0;
          if (m_ab[s]) begin
            fin = (m_ccnt[s] == 1);
            m_src[s] = m_src[s] + sx(m_sc[s]); m_dst[s] = m_dst[s] + sx(m_dc[s]);
            m_ccnt[s] = m_ccnt[s] - 1;
          end else if (m_bcnt[s] > 1) begin
            m_src[s] = m_src[s] + sx(m_sb[s]); m_dst[s] = m_dst[s] + sx(m_db[s]);
            m_bcnt[s] = m_bcnt[s] - 1;
          end else if (m_ccnt[s] > 1) begin
            m_bcnt[s] = m_brld[s]; m_ccnt[s] = m_ccnt[s] - 1;
            m_src[s] = m_src[s] + sx(m_sc[s]); m_dst[s] = m_dst[s] + sx(m_dc[s]);
          end else begin
            m_ccnt[s] = 0; fin = 1;
          end
          if (m_tgt[s] < NC && ((fin && m_fin[s]) || (!fin && m_mid[s])))
            chain[m_tgt[s][1:0]] = 1'b1;
          if (fin) begin
            m_done[s] = 1'b1;
            if (m_link[s] < NS) m_copy(s, int'(m_link[s]), 1'b0);
            else m_copy(s, 0, 1'b1);
          end
        end
      end else if (m_pend != 0) begin
        c = 0;
        for (int i = NC - 1; i >= 0; i--) if (m_pend[i]) c = i;
        clr[c] = 1'b1;
        if (m_acnt[c] == 0 || m_bcnt[c] == 0 || m_ccnt[c] == 0) m_err[c] = 1'b1;
        else begin
          m_valid = 1; m_cur = c; m_rab = m_ab[c];
          m_rsrc = m_src[c]; m_rdst = m_dst[c]; m_racnt = m_acnt[c];
          m_rbcnt = m_ab[c] ? m_bcnt[c] : 16'd1;
          m_rsb = m_sb[c]; m_rdb = m_db[c]; m_rq = m_q[c];
        end
      end
      m_pend = (m_pend & ~clr) | evt_i | chain;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      string t;
      t = m_rab ? "R2" : "R3";
      chk("R10", 32'(req_valid), 32'(m_valid), "req_valid");
      if (m_valid) begin
        chk(t, req_src, m_rsrc, "req_src");
        chk(t, req_dst, m_rdst, "req_dst");
        chk(t, 32'(req_acnt), 32'(m_racnt), "req_acnt");
        chk(t, 32'(req_bcnt), 32'(m_rbcnt), "req_bcnt");
        chk(t, {req_dbidx, req_sbidx}, {m_rdb, m_rsb}, "frame steps");
        chk("R13", 32'(req_queue), 32'(m_rq), "req_queue");
        chk("R11", 32'(req_chan), 32'(m_cur), "req_chan");
      end
      chk("R6", 32'(done_o), 32'(m_done), "done_o");
      chk("R9", 32'(err_o), 32'(m_err), "err_o");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int s, input int f, input logic [31:0] d);
    wr_en = 1; wr_set = 4'(s); wr_field = 3'(f); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [31:0] optw(input bit ab, input bit fn, input bit md, input int tgt, input int q);
    return {14'd0, 2'(q), 4'd0, 8'(tgt), 1'b0, md, fn, ab};
  endfunction

  task automatic prog(input int s, input logic [31:0] src, input logic [31:0] dst,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] cc,
                      input logic [15:0] rld, input logic [15:0] sb, input logic [15:0] db,
                      input logic [15:0] sc, input logic [15:0] dc, input logic [15:0] lnk,
                      input logic [31:0] opt);
    wr(s, 0, src); wr(s, 1, dst); wr(s, 2, {b, a}); wr(s, 3, {db, sb});
    wr(s, 4, {dc, sc}); wr(s, 5, {rld, cc}); wr(s, 6, {16'd0, lnk}); wr(s, 7, opt);
  endtask

  task automatic pulse(input logic [3:0] m);
    evt_i = m;
    @(negedge clk);
    evt_i = 0;
  endtask

  task automatic take(input int ch, input logic [31:0] es, input logic [31:0] ed,
                      input logic [15:0] eb, input int eq, input string tag);
    for (int w = 0; w < 40 && !req_valid; w++) @(negedge clk);
    chk(tag, 32'(req_valid), 1, "valid expected");
    chk(tag, 32'(req_chan), 32'(ch), "channel");
    chk(tag, req_src, es, "src");
    chk(tag, req_dst, ed, "dst");
    chk(tag, 32'(req_bcnt), 32'(eb), "bcnt");
    chk(tag, 32'(req_queue), 32'(eq), "queue");
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [15:0] lf = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 32'(req_valid), 0, "valid in reset");
    chk("R1", 32'({done_o, err_o}), 0, "flags in reset");
    rst_n = 1;
    @(negedge clk);
    cmp_en = 1;
    chk("R1", 32'(req_valid), 0, "valid after reset");
    pulse(4'b0100); @(negedge clk);
    chk("R1", 32'(err_o[2]), 1, "event on cleared descriptor");

    // block mode walk of a 64-byte buffer, reload field ignored
    prog(0, 32'h1000, 32'h2000, 4, 1, 16, 7, 0, 0, 4, 0, 16'hFFFF, optw(1, 0, 0, 0, 2));
    for (int k = 0; k < 16; k++) begin
      pulse(4'b0001);
      take(0, 32'h1000 + 32'(4 * k), 32'h2000, 1, 2, (k == 0) ? "R13" : ((k == 15) ? "R4" : "R2"));
    end
    chk("R6", 32'(done_o[0]), 1, "done after final block");
    pulse(4'b0001); @(negedge clk);
    chk("R5", 32'(err_o[0]), 1, "slot cleared without link");
    chk("R9", 32'(req_valid), 0, "no request on error");

    // frame mode with reload, negative step, link and final chain
    prog(2, 32'h5000, 32'h6000, 8, 2, 1, 0, 8, 8, 0, 0, 16'hFFFF, optw(1, 0, 0, 0, 0));
    prog(9, 32'h7000, 32'h7100, 1, 1, 1, 0, 0, 0, 0, 0, 16'hFFFF, optw(1, 0, 0, 0, 3));
    prog(1, 32'h3000, 32'h4000, 2, 2, 2, 3, 2, 16'h0010, 16'h0100, 16'hFFE0, 9, optw(0, 1, 0, 2, 1));
    pulse(4'b0010); take(1, 32'h3000, 32'h4000, 1, 1, "R3");
    pulse(4'b0010); take(1, 32'h3002, 32'h4010, 1, 1, "R3");
    pulse(4'b0010); take(1, 32'h3102, 32'h3FF0, 1, 1, "R4");
    pulse(4'b0010); take(1, 32'h3104, 32'h4000, 1, 1, "R12");
    pulse(4'b0010); take(1, 32'h3106, 32'h4010, 1, 1, "R3");
    chk("R6", 32'(done_o[1]), 1, "frame-mode job done");
    take(2, 32'h5000, 32'h6000, 2, 0, "R7");
    pulse(4'b0010); take(1, 32'h7000, 32'h7100, 1, 3, "R5");

    // intermediate chain
    prog(3, 32'h8000, 32'h9000, 4, 1, 2, 0, 0, 0, 4, 0, 16'hFFFF, optw(1, 0, 1, 0, 0));
    prog(0, 32'hA000, 32'hB000, 4, 1, 5, 0, 0, 0, 16'hFFFC, 0, 16'hFFFF, optw(1, 0, 0, 0, 0));
    pulse(4'b1000); take(3, 32'h8000, 32'h9000, 1, 0, "R2");
    take(0, 32'hA000, 32'hB000, 1, 0, "R8");
    pulse(4'b1000); take(3, 32'h8004, 32'h9000, 1, 0, "R2");
    chk("R6", 32'(done_o[3]), 1, "done with intermediate chain");
    for (int i = 0; i < 3; i++) begin
      chk("R8", 32'(req_valid), 0, "no chain after final");
      @(negedge clk);
    end
    pulse(4'b0001); take(0, 32'h9FFC, 32'hB000, 1, 0, "R12");

    // zero count
    prog(2, 32'h5000, 32'h6000, 0, 1, 1, 0, 0, 0, 0, 0, 16'hFFFF, optw(1, 0, 0, 0, 0));
    pulse(4'b0100); @(negedge clk);
    chk("R9", 32'(err_o[2]), 1, "zero acnt error");
    chk("R9", 32'(req_valid), 0, "zero acnt no request");
    wr(2, 2, {16'd1, 16'd8});
    pulse(4'b0100); take(2, 32'h5000, 32'h6000, 1, 0, "R9");

    // arbitration, back-pressure, merge
    prog(0, 32'hC000, 32'hD000, 4, 1, 3, 0, 0, 0, 4, 0, 16'hFFFF, optw(1, 0, 0, 0, 0));
    prog(1, 32'hE000, 32'hF000, 4, 1, 3, 0, 0, 0, 4, 0, 16'hFFFF, optw(1, 0, 0, 0, 0));
    req_ready = 0;
    pulse(4'b0011);
    @(negedge clk);
    chk("R11", 32'(req_chan), 0, "lowest index first");
    pulse(4'b0010);
    for (int i = 0; i < 3; i++) begin
      chk("R10", req_src, 32'hC000, "held payload");
      chk("R10", 32'(req_valid), 1, "held valid");
      @(negedge clk);
    end
    req_ready = 1;
    take(0, 32'hC000, 32'hD000, 1, 0, "R10");
    take(1, 32'hE000, 32'hF000, 1, 0, "R11");
    for (int i = 0; i < 4; i++) begin
      chk("R10", 32'(req_valid), 0, "merged events");
      @(negedge clk);
    end

    // random traffic against the model
    prog(8, 32'h10000, 32'h20000, 4, 2, 3, 2, 4, 4, 16'h0040, 16'hFFC0, 9, optw(0, 0, 0, 0, 1));
    prog(9, 32'h30000, 32'h40000, 8, 3, 2, 0, 8, 0, 16'h0100, 0, 8, optw(1, 1, 0, 3, 2));
    prog(0, 32'h0, 32'h100, 4, 3, 4, 3, 4, 16'hFFFC, 16'h0020, 4, 8, optw(0, 1, 0, 1, 0));
    prog(1, 32'h500, 32'h600, 16, 2, 3, 0, 16, 16, 32, 16'hFFF0, 9, optw(1, 0, 1, 2, 1));
    prog(2, 32'h900, 32'hA00, 1, 4, 2, 4, 1, 1, 8, 8, 8, optw(0, 0, 1, 3, 2));
    prog(3, 32'hD00, 32'hE00, 2, 1, 6, 0, 0, 0, 2, 2, 9, optw(1, 1, 0, 0, 3));
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      evt_i = lf[3:0] & lf[7:4] & lf[11:8];
      req_ready = lf[14] | lf[9];
      @(negedge clk);
    end
    evt_i = 0; req_ready = 1;
    repeat (40) @(negedge clk);
    cmp_en = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule